// File: doc/BRIEF.md
# Control-Flow Next-PC Unit

This unit works out where a 64-bit load/store core fetches next after a control-flow instruction, and which register writes that instruction makes. Each cycle it takes the current program counter, a 3-bit class code, two register operands, a 26-bit jump index and a 16-bit branch offset. It returns the next PC, a taken flag, a link write (value and destination register) and a conditional-move write, all from one register stage.

Three kinds of target exist. A region jump keeps the upper 36 PC bits and places the jump index, scaled by four, below them. A register jump uses the first operand directly. A relative branch adds the sign-extended offset, scaled by four, to the address of the next sequential instruction. Linking instructions save PC+8. A single zero detector serves both the zero branch and the conditional move. The move tests the second operand and the branch tests the first.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, every output is zero. The reset takes effect at once, without waiting for a clock edge.
- R2: Outputs are registered. After each rising clock edge they show the result for the inputs sampled at that edge. Class codes: 0 sequential, 1 jump, 2 jump-and-link, 3 jump-register, 4 jump-and-link-register, 5 branch-if-zero, 6 branch-if-not-equal, 7 conditional move.
- R3: For class 0, `next_pc` is PC+4, `taken` is 0, and neither write enable is set.
- R4: For class 1, `next_pc` is {PC[63:28], jump_idx, 2'b00} and `taken` is 1. No link write occurs.
- R5: For class 2, the target is the same as for class 1 and `taken` is 1. `link_we` is 1 and `link_rd` is 31.
- R6: For class 3, `next_pc` equals `src_a` and `taken` is 1. No link write occurs.
- R7: For class 4, `next_pc` equals `src_a`, `taken` is 1, `link_we` is 1 and `link_rd` is 31.
- R8: For class 5, the branch is taken exactly when `src_a` is zero. The taken target is PC+4 plus the sign-extended offset shifted left by two. Otherwise `next_pc` is PC+4. `src_b` and `jump_idx` have no effect.
- R9: For class 6, the branch is taken exactly when `src_a` differs from `src_b`. It uses the same taken and fall-through targets as R8.
- R10: For class 7, `cmov_we` is 1 exactly when `src_b` is zero. `next_pc` is PC+4, `taken` is 0, and `link_we` is 0.
- R11: `link_val` is always PC+8 and `cmov_data` is always `src_a`. `link_rd` is 31 when `link_we` is set and 0 otherwise.
- R12: All address sums wrap modulo 2^64. This covers PC+4, PC+8 and backward branch offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_pc | input | 64 | Address of the control-flow instruction |
| op_class | input | 3 | Instruction class code |
| src_a | input | 64 | First register operand |
| src_b | input | 64 | Second register operand |
| jump_idx | input | 26 | Region jump index |
| br_off | input | 16 | Signed branch offset in instruction words |
| next_pc | output | 64 | Address to fetch next |
| taken | output | 1 | Control flow leaves the sequential path |
| link_we | output | 1 | Link register write enable |
| link_val | output | 64 | Return address PC+8 |
| link_rd | output | 5 | Link destination register |
| cmov_we | output | 1 | Conditional-move write enable |
| cmov_data | output | 64 | Data for the conditional move |

## Verification
A vector table applies every class code. The branches get zero and nonzero first operands and equal and unequal operand pairs, which shows the zero test apart from the inequality test. The conditional move gets a zero `src_b` paired with a nonzero `src_a`, and the reverse, which shows that the shared detector picks the right operand for each class. Jumps run from PCs with distinct upper bits, so a region target is kept apart from one built from zeros or from a register. Further vectors use PCs and offsets at the 64-bit boundary and the most negative offset, and a reset is raised in the middle of the run.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [2:0] {
    NPC_SEQ   = 3'd0,
    NPC_JMP   = 3'd1,
    NPC_JAL   = 3'd2,
    NPC_JR    = 3'd3,
    NPC_JALR  = 3'd4,
    NPC_BEQZ  = 3'd5,
    NPC_BNE   = 3'd6,
    NPC_CMOVZ = 3'd7
  } npc_op_e;

  typedef enum logic [1:0] {
    TGT_SEQ    = 2'd0,
    TGT_REGION = 2'd1,
    TGT_BRANCH = 2'd2,
    TGT_REG    = 2'd3
  } tgt_sel_e;

  typedef struct packed {
    tgt_sel_e sel;
    logic     jump_uncond;
    logic     br_on_zero;
    logic     br_on_ne;
    logic     link;
    logic     cmov;
    logic     zero_on_b;
  } npc_ctl_t;

endpackage

// File: rtl/npc_cond.sv
module npc_cond #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic            zero_on_b,
  output logic            is_zero,
  output logic            differ
);

  logic [XLEN-1:0] zero_src;

  // One zero detector shared by the zero branch (tests opa) and the move (tests opb).
  always_comb begin
    zero_src = zero_on_b ? opb : opa;
    is_zero  = ~|zero_src;
    differ   = |(opa ^ opb);
  end

endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int JIDX_W     = 26,
  parameter int OFF_W      = 16,
  parameter int WORD_SHIFT = 2
) (
  input  logic [XLEN-1:0]   pc,
  input  logic [JIDX_W-1:0] jidx,
  input  logic [OFF_W-1:0]  boff,
  input  logic [XLEN-1:0]   reg_tgt,
  input  tgt_sel_e          sel,
  output logic [XLEN-1:0]   target,
  output logic [XLEN-1:0]   seq_pc,
  output logic [XLEN-1:0]   link_pc
);

  localparam int INSN_BYTES = 1 << WORD_SHIFT;
  localparam int LOW_W      = JIDX_W + WORD_SHIFT;
  localparam int KEEP_W     = XLEN - LOW_W;
  localparam int SEXT_W     = XLEN - OFF_W - WORD_SHIFT;

  logic [XLEN-1:0] region_tgt;
  logic [XLEN-1:0] off_ext;
  logic [XLEN-1:0] branch_tgt;

  generate
    if (KEEP_W > 0) begin : g_keep
      assign region_tgt = {pc[XLEN-1:LOW_W], jidx, {WORD_SHIFT{1'b0}}};
    end else begin : g_nokeep
      assign region_tgt = XLEN'({jidx, {WORD_SHIFT{1'b0}}});
    end
  endgenerate

  always_comb begin
    seq_pc     = pc + XLEN'(INSN_BYTES);
    link_pc    = pc + XLEN'(2 * INSN_BYTES);
    off_ext    = {{SEXT_W{boff[OFF_W-1]}}, boff, {WORD_SHIFT{1'b0}}};
    branch_tgt = seq_pc + off_ext;
    unique case (sel)
      TGT_REGION: target = region_tgt;
      TGT_BRANCH: target = branch_tgt;
      TGT_REG:    target = reg_tgt;
      default:    target = seq_pc;
    endcase
  end

endmodule

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [2:0] op_class,
  output npc_ctl_t   ctl
);

  npc_op_e op;

  always_comb begin
    op  = npc_op_e'(op_class);
    ctl = '{sel: TGT_SEQ, jump_uncond: 1'b0, br_on_zero: 1'b0,
            br_on_ne: 1'b0, link: 1'b0, cmov: 1'b0, zero_on_b: 1'b0};
    unique case (op)
      NPC_JMP: begin
        ctl.sel         = TGT_REGION;
        ctl.jump_uncond = 1'b1;
      end
      NPC_JAL: begin
        ctl.sel         = TGT_REGION;
        ctl.jump_uncond = 1'b1;
        ctl.link        = 1'b1;
      end
      NPC_JR: begin
        ctl.sel         = TGT_REG;
        ctl.jump_uncond = 1'b1;
      end
      NPC_JALR: begin
        ctl.sel         = TGT_REG;
        ctl.jump_uncond = 1'b1;
        ctl.link        = 1'b1;
      end
      NPC_BEQZ: begin
        ctl.sel        = TGT_BRANCH;
        ctl.br_on_zero = 1'b1;
      end
      NPC_BNE: begin
        ctl.sel      = TGT_BRANCH;
        ctl.br_on_ne = 1'b1;
      end
      NPC_CMOVZ: begin
        ctl.cmov      = 1'b1;
        ctl.zero_on_b = 1'b1;
      end
      default: ctl.sel = TGT_SEQ;
    endcase
  end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int JIDX_W   = 26,
  parameter int OFF_W    = 16,
  parameter int REG_W    = 5,
  parameter int LINK_REG = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [2:0]        op_class,
  input  logic [XLEN-1:0]   src_a,
  input  logic [XLEN-1:0]   src_b,
  input  logic [JIDX_W-1:0] jump_idx,
  input  logic [OFF_W-1:0]  br_off,
  output logic [XLEN-1:0]   next_pc,
  output logic              taken,
  output logic              link_we,
  output logic [XLEN-1:0]   link_val,
  output logic [REG_W-1:0]  link_rd,
  output logic              cmov_we,
  output logic [XLEN-1:0]   cmov_data
);

  localparam logic [REG_W-1:0] LINK_IDX = REG_W'(LINK_REG);

  npc_ctl_t        ctl;
  logic            is_zero;
  logic            differ;
  logic [XLEN-1:0] tgt_raw;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] link_pc;
  logic            take_d;
  logic [XLEN-1:0] npc_d;
  logic            cmov_d;
  logic            out_en;

  npc_decode u_dec (
    .op_class (op_class),
    .ctl      (ctl)
  );

  npc_cond #(.XLEN(XLEN)) u_cond (
    .opa       (src_a),
    .opb       (src_b),
    .zero_on_b (ctl.zero_on_b),
    .is_zero   (is_zero),
    .differ    (differ)
  );

  npc_target #(.XLEN(XLEN), .JIDX_W(JIDX_W), .OFF_W(OFF_W)) u_tgt (
    .pc      (cur_pc),
    .jidx    (jump_idx),
    .boff    (br_off),
    .reg_tgt (src_a),
    .sel     (ctl.sel),
    .target  (tgt_raw),
    .seq_pc  (seq_pc),
    .link_pc (link_pc)
  );

  // Next-state logic
  always_comb begin
    out_en = 1'b1;
    take_d = ctl.jump_uncond
           | (ctl.br_on_zero & is_zero)
           | (ctl.br_on_ne & differ);
    npc_d  = take_d ? tgt_raw : seq_pc;
    cmov_d = ctl.cmov & is_zero;
  end

  // Output register stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_pc   <= '0;
      taken     <= 1'b0;
      link_we   <= 1'b0;
      link_val  <= '0;
      link_rd   <= '0;
      cmov_we   <= 1'b0;
      cmov_data <= '0;
    end else if (out_en) begin
      next_pc   <= npc_d;
      taken     <= take_d;
      link_we   <= ctl.link;
      link_val  <= link_pc;
      link_rd   <= ctl.link ? LINK_IDX : '0;
      cmov_we   <= cmov_d;
      cmov_data <= src_a;
    end
  end

  // Assertion support: marks the first edge after reset release.
  logic primed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed_q <= 1'b0;
    else        primed_q <= 1'b1;
  end

  // R3: a sequential class steps the PC by one instruction.
  a_r3_seq_step: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
    ($past(op_class) == 3'd0) |-> (next_pc == $past(cur_pc) + 64'd4 && !taken && !link_we && !cmov_we));

  // R4: a region jump keeps the upper PC bits.
  a_r4_region_keep: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
    ($past(op_class) == 3'd1) |-> (next_pc[63:28] == $past(cur_pc[63:28]) && taken));

  // R7: a register jump with link follows src_a.
  a_r7_reg_target: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
    ($past(op_class) == 3'd4) |-> (next_pc == $past(src_a) && link_we));

  // R9: the inequality branch follows the operand comparison.
  a_r9_bne_taken: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
    ($past(op_class) == 3'd6) |-> (taken == ($past(src_a) != $past(src_b))));

  // R10: the conditional move depends only on src_b being zero.
  a_r10_cmov_zero: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
    ($past(op_class) == 3'd7) |-> (cmov_we == ($past(src_b) == 64'd0) && !taken));

  // R11: the link destination is used only together with the link enable.
  a_r11_link_rd: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
    link_we |-> (link_rd == LINK_IDX && link_val == $past(cur_pc) + 64'd8));

endmodule

// File: tb/npc_unit_tb.sv
module npc_unit_tb;

  typedef struct packed {
    logic [2:0]  op;
    logic [63:0] pc;
    logic [63:0] a;
    logic [63:0] b;
    logic [25:0] j;
    logic [15:0] off;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 64'h0000_0000_0040_0000, 64'h5, 64'h6, 26'h3FF_FFFF, 16'h0010},
    '{3'd1, 64'hA5A5_0000_1234_5670, 64'h0, 64'h0, 26'h155_5555, 16'h0000},
    '{3'd1, 64'hF000_0000_F000_0008, 64'h1, 64'h1, 26'h000_0001, 16'hFFFF},
    '{3'd2, 64'h1234_5678_9ABC_DEF0, 64'h9, 64'h0, 26'h2AA_AAAA, 16'h0004},
    '{3'd3, 64'h0000_0000_0001_0000, 64'hDEAD_BEEF_0000_0100, 64'h0, 26'h0, 16'h0},
    '{3'd4, 64'h0000_0000_0002_0000, 64'h0000_0000_0000_0000, 64'h7, 26'h123, 16'h8},
    '{3'd5, 64'h0000_0000_0000_1000, 64'h0, 64'hFFFF, 26'h3FF_FFFF, 16'h0010},
    '{3'd5, 64'h0000_0000_0000_1000, 64'h1, 64'h0, 26'h0, 16'h0010},
    '{3'd5, 64'h0000_0000_0000_1000, 64'h0, 64'h0, 26'h0, 16'hFFF0},
    '{3'd6, 64'h0000_0000_0000_2000, 64'h33, 64'h33, 26'h0, 16'h0020},
    '{3'd6, 64'h0000_0000_0000_2000, 64'h33, 64'h34, 26'h0, 16'h0020},
    '{3'd6, 64'h0000_0000_0000_2000, 64'h8000_0000_0000_0000, 64'h0, 26'h0, 16'h8000},
    '{3'd7, 64'h0000_0000_0000_3000, 64'hCAFE, 64'h0, 26'h0, 16'h0},
    '{3'd7, 64'h0000_0000_0000_3000, 64'h0, 64'hCAFE, 26'h0, 16'h0},
    '{3'd0, 64'hFFFF_FFFF_FFFF_FFFC, 64'h0, 64'h0, 26'h0, 16'h0},
    '{3'd2, 64'hFFFF_FFFF_FFFF_FFFC, 64'h0, 64'h0, 26'h0, 16'h0},
    '{3'd5, 64'h0000_0000_0000_0000, 64'h0, 64'h0, 26'h0, 16'hFFFF},
    '{3'd6, 64'hFFFF_FFFF_FFFF_FFF8, 64'h1, 64'h2, 26'h0, 16'h0001}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] cur_pc, src_a, src_b;
  logic [2:0]  op_class;
  logic [25:0] jump_idx;
  logic [15:0] br_off;
  logic [63:0] next_pc, link_val, cmov_data;
  logic        taken, link_we, cmov_we;
  logic [4:0]  link_rd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  npc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .op_class(op_class),
    .src_a(src_a), .src_b(src_b), .jump_idx(jump_idx), .br_off(br_off),
    .next_pc(next_pc), .taken(taken), .link_we(link_we), .link_val(link_val),
    .link_rd(link_rd), .cmov_we(cmov_we), .cmov_data(cmov_data)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      3'd6: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic apply(input vec_t v);
    @(negedge clk);
    op_class = v.op; cur_pc = v.pc; src_a = v.a; src_b = v.b;
    jump_idx = v.j; br_off = v.off;
  endtask

  // Expected values derived from the requirements (R2 latency: check at the next negedge).
  task automatic expect_vec(input vec_t v, input string extra);
    logic [63:0] seq, btgt, rtgt, exp_pc;
    logic        exp_tk, exp_lk, exp_cm;
    string       r;
    seq    = v.pc + 64'd4;
    btgt   = seq + {{46{v.off[15]}}, v.off, 2'b00};
    rtgt   = {v.pc[63:28], v.j, 2'b00};
    exp_lk = (v.op == 3'd2) || (v.op == 3'd4);
    exp_cm = (v.op == 3'd7) && (v.b == 64'd0);
    case (v.op)
      3'd1, 3'd2: begin exp_tk = 1'b1; exp_pc = rtgt; end
      3'd3, 3'd4: begin exp_tk = 1'b1; exp_pc = v.a; end
      3'd5: begin exp_tk = (v.a == 64'd0); exp_pc = exp_tk ? btgt : seq; end
      3'd6: begin exp_tk = (v.a != v.b); exp_pc = exp_tk ? btgt : seq; end
      default: begin exp_tk = 1'b0; exp_pc = seq; end
    endcase
    r = {req_of(v.op), extra};
    @(negedge clk);
    chk(r, "next_pc", next_pc, exp_pc);
    chk(r, "taken", 64'(taken), 64'(exp_tk));
    chk(r, "link_we", 64'(link_we), 64'(exp_lk));
    chk(r, "cmov_we", 64'(cmov_we), 64'(exp_cm));
    chk("R11", "link_val", link_val, v.pc + 64'd8);
    chk("R11", "link_rd", 64'(link_rd), exp_lk ? 64'd31 : 64'd0);
    chk("R11", "cmov_data", cmov_data, v.a);
  endtask

  task automatic check_zero(input string tag);
    chk(tag, "next_pc", next_pc, 64'd0);
    chk(tag, "flags", 64'({taken, link_we, cmov_we}), 64'd0);
    chk(tag, "link_val", link_val, 64'd0);
    chk(tag, "link_rd", 64'(link_rd), 64'd0);
    chk(tag, "cmov_data", cmov_data, 64'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    op_class = 3'd0; cur_pc = '0; src_a = '0; src_b = '0;
    jump_idx = '0; br_off = '0;
    repeat (3) @(negedge clk);
    check_zero("R1");
    rst_n = 1'b1;

    // Table walk covers R2 through R11; the tail rows cover R12 wraparound.
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      expect_vec(VECS[i], (i >= 14) ? "/R12" : "/R2");
    end

    // R8: src_b and jump_idx must not influence a zero branch.
    apply('{3'd5, 64'h4000, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 26'h3FF_FFFF, 16'h0002});
    expect_vec('{3'd5, 64'h4000, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 26'h3FF_FFFF, 16'h0002}, "/ignore");

    // R1: a reset raised mid-run clears the outputs without a clock edge.
    apply('{3'd2, 64'h8000, 64'h1, 64'h1, 26'h5, 16'h1});
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    #0.5;
    check_zero("R1");
    @(negedge clk);
    rst_n = 1'b1;
    apply('{3'd3, 64'h9000, 64'h1_0000_0000, 64'h0, 26'h0, 16'h0});
    expect_vec('{3'd3, 64'h9000, 64'h1_0000_0000, 64'h0, 26'h0, 16'h0}, "/after_reset");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule